// File: doc/BRIEF.md
# Sparse Hit-Pattern Readout Packer

This block takes one event's worth of results from sixteen conversion channels and serialises it into a tagged stream of 16-bit words. An event strobe captures a hit mask and sixteen parallel conversion values. The packer then emits the packet on a valid/ready word stream. The packet starts with a fixed opening tag, followed by the hit mask, followed by one word for each flagged channel, and ends with a fixed closing tag. Each channel word carries the channel number in its top nibble and the conversion value in its low twelve bits.

While a packet is leaving the block, a busy flag is high and further strobes are ignored. The producer can therefore fire strobes freely, and an event that lands on a busy packer is dropped as a whole. The downstream consumer may hold ready low for any length of time without losing or altering a word.

Top module: `hitpack_packer`

## Requirements
- R1: The first word of every packet is the opening tag 0x7186.
- R2: The second word is the captured hit mask, with bit i standing for channel i.
- R3: Exactly one channel word is emitted for each set mask bit, and none is emitted for a clear bit.
- R4: A channel word holds the channel number (0 to 15) in bits 15:12 and the conversion value in bits 11:0.
- R5: Channel words leave in strictly ascending channel order.
- R6: A zero hit mask gives a packet of exactly three words: opening tag, mask, closing tag.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R8: busy is high from the cycle after an accepted strobe until the cycle after the closing tag is accepted, and out_valid is high only while busy is high. Both are low after reset.
- R9: A strobe that arrives while busy is high is ignored: the current packet completes with its captured data, and no further packet follows.
- R10: Each conversion input of RAW_W bits contributes only its low 12 bits to its channel word.
- R11: The last word of every packet is the closing tag 0xF186.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | 1 | Event strobe, captures mask and values when idle |
| hit_mask | input | NCH | Per-channel hit flags |
| conv_vals | input | NCH*RAW_W | Conversion values, channel i at bits i*RAW_W upward |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | out_data holds a packet word |
| out_data | output | 16 | Packet word |
| busy | output | 1 | A packet is in progress |

## Verification
The bench builds the packer with sixteen channels and RAW_W set to 14, so every conversion input has two bits above the twelve kept. This makes truncation visible at the output. It also makes it possible to give channel 15 a value whose channel word equals the closing tag. Stimuli include empty, full, sparse and edge masks. Consumer ready is driven in three modes: held high, held low, and following a pseudo-random pattern. A second strobe is fired into a stalled packet to check that it is dropped.

// File: rtl/hitpack_pkg.sv
package hitpack_pkg;

    localparam int WORD_W   = 16;
    localparam int VAL_W    = 12;
    localparam int CHN_BITS = WORD_W - VAL_W;
    localparam int NCH_DEF  = 16;

    localparam logic [WORD_W-1:0] TAG_OPEN  = 16'h7186;
    localparam logic [WORD_W-1:0] TAG_CLOSE = 16'hF186;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TAG  = 3'd1,
        PH_MASK = 3'd2,
        PH_DATA = 3'd3,
        PH_END  = 3'd4
    } phase_t;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [CHN_BITS-1:0] ch,
        input logic [VAL_W-1:0]    val
    );
        return {ch, val};
    endfunction

endpackage

// File: rtl/hitpack_capture.sv
module hitpack_capture
    import hitpack_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int RAW_W = VAL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 clr_en,
    input  logic [NCH-1:0]       pend_next,
    input  logic [NCH-1:0]       mask_in,
    input  logic [NCH*RAW_W-1:0] vals_in,
    output logic [NCH-1:0]       mask_q,
    output logic [NCH-1:0]       pend_q,
    output logic [VAL_W-1:0]     vals_q [NCH]
);

    logic [VAL_W-1:0] trunc [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        if (RAW_W >= VAL_W) begin : g_cut
            assign trunc[i] = vals_in[i*RAW_W +: VAL_W];
        end else begin : g_ext
            assign trunc[i] = VAL_W'(vals_in[i*RAW_W +: RAW_W]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vals_q[i] <= '0;
            end else if (load) begin
                vals_q[i] <= trunc[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
        end else if (load) begin
            mask_q <= mask_in;
            pend_q <= mask_in;
        end else if (clr_en) begin
            pend_q <= pend_next;
        end
    end

endmodule

// File: rtl/hitpack_scan.sv
module hitpack_scan
    import hitpack_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  pending,
    output logic            any,
    output logic [CH_W-1:0] idx,
    output logic [NCH-1:0]  pend_next,
    output logic            rest_empty
);

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx = CH_W'(i);
            end
        end
    end

    assign any        = |pending;
    assign pend_next  = pending & ~(NCH'(1) << idx);
    assign rest_empty = ~|pend_next;

endmodule

// File: rtl/hitpack_seq.sv
module hitpack_seq
    import hitpack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_req,
    input  logic   pend_any,
    input  logic   rest_empty,
    input  logic   out_ready,
    output phase_t phase,
    output logic   load,
    output logic   data_fire,
    output logic   out_valid,
    output logic   busy
);

    phase_t phase_nx;
    logic   fire;

    assign out_valid = (phase != PH_IDLE);
    assign busy      = (phase != PH_IDLE);
    assign load      = start_req && (phase == PH_IDLE);
    assign fire      = out_valid && out_ready;
    assign data_fire = fire && (phase == PH_DATA);

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (load) phase_nx = PH_TAG;
            PH_TAG:  if (fire) phase_nx = PH_MASK;
            PH_MASK: if (fire) phase_nx = pend_any ? PH_DATA : PH_END;
            PH_DATA: if (fire && rest_empty) phase_nx = PH_END;
            PH_END:  if (fire) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

endmodule

// File: rtl/hitpack_packer.sv
module hitpack_packer
    import hitpack_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int RAW_W = VAL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_stb,
    input  logic [NCH-1:0]       hit_mask,
    input  logic [NCH*RAW_W-1:0] conv_vals,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_data,
    output logic                 busy
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    phase_t           phase;
    logic             load;
    logic             data_fire;
    logic             pend_any;
    logic             rest_empty;
    logic [CH_W-1:0]  idx;
    logic [NCH-1:0]   pend_next;
    logic [NCH-1:0]   mask_q;
    logic [NCH-1:0]   pend_q;
    logic [VAL_W-1:0] vals_q [NCH];

    hitpack_capture #(.NCH(NCH), .RAW_W(RAW_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .clr_en   (data_fire),
        .pend_next(pend_next),
        .mask_in  (hit_mask),
        .vals_in  (conv_vals),
        .mask_q   (mask_q),
        .pend_q   (pend_q),
        .vals_q   (vals_q)
    );

    hitpack_scan #(.NCH(NCH)) u_scan (
        .pending   (pend_q),
        .any       (pend_any),
        .idx       (idx),
        .pend_next (pend_next),
        .rest_empty(rest_empty)
    );

    hitpack_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (evt_stb),
        .pend_any  (pend_any),
        .rest_empty(rest_empty),
        .out_ready (out_ready),
        .phase     (phase),
        .load      (load),
        .data_fire (data_fire),
        .out_valid (out_valid),
        .busy      (busy)
    );

    always_comb begin
        case (phase)
            PH_TAG:  out_data = TAG_OPEN;
            PH_MASK: out_data = WORD_W'(mask_q);
            PH_DATA: out_data = pack_word(CHN_BITS'(idx), vals_q[idx]);
            PH_END:  out_data = TAG_CLOSE;
            default: out_data = '0;
        endcase
    end

endmodule

// File: rtl/hitpack_chk.sv
module hitpack_chk
    import hitpack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              busy,
    input phase_t            phase
);

    logic [CHN_BITS-1:0] prev_ch;
    logic                have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ch   <= '0;
            have_prev <= 1'b0;
        end else if (phase == PH_TAG) begin
            have_prev <= 1'b0;
        end else if (phase == PH_DATA && out_valid && out_ready) begin
            prev_ch   <= out_data[WORD_W-1:VAL_W];
            have_prev <= 1'b1;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1
    open_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_data == 16'h7186));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid);

    // R5
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && out_valid && have_prev) |-> (out_data[WORD_W-1:VAL_W] > prev_ch));

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_END && out_valid && out_ready) |=> (!busy && !out_valid));

endmodule

bind hitpack_packer hitpack_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .busy     (busy),
    .phase    (phase)
);

// File: tb/hitpack_packer_tb.sv
module hitpack_packer_tb;

    localparam int NCH   = 16;
    localparam int RAW_W = 14;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 evt_stb = 1'b0;
    logic [NCH-1:0]       hit_mask = '0;
    logic [NCH*RAW_W-1:0] conv_vals = '0;
    logic                 out_ready = 1'b0;
    logic                 out_valid;
    logic [15:0]          out_data;
    logic                 busy;

    int checks = 0;
    int failures = 0;
    int rdy_mode = 1;
    logic [15:0] lfsr = 16'hACE1;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    int          pkt_words = 0;
    logic        end_seen = 1'b0;
    logic        held_v = 1'b0;
    logic [15:0] held_d = '0;

    always #10 clk = ~clk;

    hitpack_packer #(.NCH(NCH), .RAW_W(RAW_W)) u_dut (
        .clk(clk), .rst(rst), .evt_stb(evt_stb), .hit_mask(hit_mask),
        .conv_vals(conv_vals), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready <= 1'b0;
            1: out_ready <= 1'b1;
            default: out_ready <= lfsr[3] | lfsr[7];
        endcase
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (end_seen) begin
                check(!busy, "R8 busy low after close", 32'(busy), 0);
                end_seen = 1'b0;
            end
            if (held_v) begin
                check(out_valid && out_data == held_d, "R7 stalled word held", 32'(out_data), 32'(held_d));
            end
            if (out_valid && !busy) check(0, "R8 valid without busy", 1, 0);
            held_v = out_valid && !out_ready;
            held_d = out_data;
            if (out_valid && out_ready) begin
                pkt_words++;
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected word", 32'(out_data), 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, 32'(out_data), 32'(e));
                    if (exp_q.size() == 0) end_seen = 1'b1;
                end
            end
        end
    end

    function automatic logic [NCH*RAW_W-1:0] make_vals(input int seed);
        logic [NCH*RAW_W-1:0] v;
        logic [31:0] s;
        s = 32'(seed) * 32'h9E3779B1 + 32'h1234;
        for (int i = 0; i < NCH; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            v[i*RAW_W +: RAW_W] = s[29:16];
        end
        return v;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic send_event(input logic [15:0] m, input logic [NCH*RAW_W-1:0] v, input bit poke);
        wait_idle();
        @(posedge clk); #2;
        hit_mask = m; conv_vals = v; evt_stb = 1'b1;
        pkt_words = 0;
        exp_q.push_back(16'h7186); tag_q.push_back("R1 open tag");
        exp_q.push_back(m);        tag_q.push_back("R2 mask word");
        for (int ch = 0; ch < NCH; ch++) begin
            if (m[ch]) begin
                exp_q.push_back({4'(ch), v[ch*RAW_W +: 12]});
                tag_q.push_back("R4 R10 R5 channel word");
            end
        end
        exp_q.push_back(16'hF186); tag_q.push_back("R11 close tag");
        @(posedge clk); #2;
        evt_stb = 1'b0;
        hit_mask = ~m; conv_vals = ~v;
        @(negedge clk);
        check(busy == 1'b1, "R8 busy after strobe", 32'(busy), 1);
        if (poke) begin
            // R9: second strobe while the packet is stalled
            @(posedge clk); #2;
            evt_stb = 1'b1;
            @(posedge clk); #2;
            evt_stb = 1'b0;
            repeat (2) @(posedge clk);
            #2 rdy_mode = 2;
        end
        wait_idle();
        check(exp_q.size() == 0, "R3 all expected words seen", 32'(exp_q.size()), 0);
        if (poke) begin
            repeat (6) begin
                @(negedge clk);
                check(!out_valid && !busy, "R9 no packet from ignored strobe", 32'(out_valid), 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !busy, "R8 reset state", 32'({out_valid, busy}), 0);
        @(posedge clk); #2 rst = 1'b0;

        // R6: empty mask gives three words
        rdy_mode = 1;
        send_event(16'h0000, make_vals(1), 0);
        check(pkt_words == 3, "R6 empty packet length", 32'(pkt_words), 3);

        send_event(16'hFFFF, make_vals(2), 0);
        check(pkt_words == 19, "R3 full packet length", 32'(pkt_words), 19);
        send_event(16'h8001, make_vals(3), 0);
        send_event(16'h0001, make_vals(4), 0);
        begin
            logic [NCH*RAW_W-1:0] v;
            v = make_vals(5);
            v[15*RAW_W +: RAW_W] = 14'h3186; // channel word equals close tag, top bits cut (R10)
            send_event(16'h8000, v, 0);
        end

        rdy_mode = 2;
        send_event(16'hA5A5, make_vals(6), 0);
        send_event(16'h0000, make_vals(7), 0);
        check(pkt_words == 3, "R6 empty packet under stall", 32'(pkt_words), 3);
        for (int k = 0; k < 12; k++) begin
            send_event(16'(k * 16'h3D17 + 16'h0421), make_vals(10 + k), 0);
        end

        // R9
        rdy_mode = 0;
        send_event(16'h0F0F, make_vals(40), 1);
        rdy_mode = 1;
        send_event(16'h4002, make_vals(41), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule